// File: doc/BRIEF.md
# DVFS Performance Level Controller

The block steers a processor clock and its supply voltage between a small set of discrete performance levels. Software names a target as a percentage; the block rounds it to the nearest available level and looks that level up in a programmable table that gives a clock divider select and a regulator voltage code. A hardware input can demand full performance at any moment. When that input is released, the block returns to whatever target software last wrote.

Moves between levels are made one level at a time, so the clock never runs faster than the present supply supports. On the way up, the block requests the higher voltage first and switches the divider only when the regulator reports the new voltage stable. On the way down, it slows the divider first and then lowers the voltage. The regulator is outside the block and answers each request with a one-cycle stable pulse. The current level index advances at each stable point. A one-cycle interrupt marks the moment the current index reaches the target.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset, current_idx and target_idx are 0 and irq is 0. The table holds div = NLVL-1-i and volt = i for level i, and div_sel and volt_req show the level 0 entry.
- R2: A write on req_we sets the software target to the level i whose value (i+1)*100/NLVL is nearest to req_pct. Values above 100 count as 100, and an exact tie takes the higher level. target_idx shows the new index in the cycle after the write.
- R3: While max_perf is 1, target_idx is NLVL-1 and the controller never starts a downward step.
- R4: When max_perf falls, target_idx returns to the latest software target, including any target written while the override was held.
- R5: On an upward step, volt_req changes to the next level's code first. div_sel and current_idx change together, on the edge that samples vreg_ack; div_sel does not change before that edge.
- R6: On a downward step, div_sel changes to the next lower level first. volt_req changes one cycle later. current_idx decrements on the edge that samples vreg_ack.
- R7: current_idx changes by exactly one per step and rests only when it equals target_idx.
- R8: If the target changes during a step, that step completes first. The controller then moves toward the new target.
- R9: irq is a one-cycle pulse, raised on the edge where a completed step makes current_idx equal target_idx.
- R10: vreg_ack has no effect while no step is waiting for it.
- R11: A write on lut_we replaces the div and volt entry of level lut_idx, and later steps to that level drive the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_we | input | 1 | Write strobe for the software target |
| req_pct | input | REQW | Requested performance in percent |
| lut_we | input | 1 | Write strobe for a table entry |
| lut_idx | input | IDXW | Level whose entry is written |
| lut_div | input | DIVW | Divider select for that level |
| lut_volt | input | VOLTW | Voltage code for that level |
| max_perf | input | 1 | Hardware full-performance override |
| vreg_ack | input | 1 | Regulator pulse: requested voltage is stable |
| div_sel | output | DIVW | Clock divider select |
| volt_req | output | VOLTW | Voltage code sent to the regulator |
| target_idx | output | IDXW | Effective target level |
| current_idx | output | IDXW | Level presently in force |
| irq | output | 1 | Target-reached pulse |

## Verification
The bench uses the defaults: four levels, a 3-bit divider select, 4-bit voltage codes and a 7-bit percentage. With four levels, every request value from 0 to 127 can be swept and its rounding checked against a nearest-distance search. With the default table, where div and volt mirror the index, the ordering of divider and voltage changes can be checked on every step. A regulator model in the bench answers each new voltage code after three cycles. This leaves room to retarget in the middle of a step and to inject stray acknowledges.

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl #(
  parameter int NLVL  = 4,
  parameter int DIVW  = 3,
  parameter int VOLTW = 4,
  parameter int REQW  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_we,
  input  logic [REQW-1:0]          req_pct,
  input  logic                     lut_we,
  input  logic [$clog2(NLVL)-1:0]  lut_idx,
  input  logic [DIVW-1:0]          lut_div,
  input  logic [VOLTW-1:0]         lut_volt,
  input  logic                     max_perf,
  input  logic                     vreg_ack,
  output logic [DIVW-1:0]          div_sel,
  output logic [VOLTW-1:0]         volt_req,
  output logic [$clog2(NLVL)-1:0]  target_idx,
  output logic [$clog2(NLVL)-1:0]  current_idx,
  output logic                     irq
);
  localparam int IDXW = $clog2(NLVL);
  localparam int PCT  = 100;
  localparam logic [IDXW-1:0] TOP = IDXW'(NLVL - 1);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_DNV, S_DNW} st_t;
  st_t st;

  logic [DIVW-1:0]  div_tab  [NLVL];
  logic [VOLTW-1:0] volt_tab [NLVL];
  logic [IDXW-1:0]  sw_tgt, cur, eff, up_i, dn_i, req_idx;
  logic [REQW-1:0]  pct_c;
  int               q;

  assign pct_c = (req_pct > REQW'(PCT)) ? REQW'(PCT) : req_pct;
  always_comb begin
    q = (int'(pct_c) * 2 * NLVL + PCT) / (2 * PCT);
    if (q == 0)         req_idx = '0;
    else if (q > NLVL)  req_idx = TOP;
    else                req_idx = IDXW'(q - 1);
  end

  assign eff         = max_perf ? TOP : sw_tgt;
  assign up_i        = cur + 1'b1;
  assign dn_i        = cur - 1'b1;
  assign target_idx  = eff;
  assign current_idx = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sw_tgt   <= '0;
      cur      <= '0;
      irq      <= 1'b0;
      div_sel  <= DIVW'(NLVL - 1);
      volt_req <= '0;
      for (int i = 0; i < NLVL; i++) begin
        div_tab[i]  <= DIVW'(NLVL - 1 - i);
        volt_tab[i] <= VOLTW'(i);
      end
    end else begin
      irq <= 1'b0;
      if (req_we) sw_tgt <= req_idx;
      if (lut_we) begin
        div_tab[lut_idx]  <= lut_div;
        volt_tab[lut_idx] <= lut_volt;
      end
      case (st)
        S_IDLE:
          if (eff > cur) begin
            volt_req <= volt_tab[up_i];
            st       <= S_UP;
          end else if (eff < cur) begin
            div_sel <= div_tab[dn_i];
            st      <= S_DNV;
          end
        S_UP:
          if (vreg_ack) begin
            div_sel <= div_tab[up_i];
            cur     <= up_i;
            irq     <= (up_i == eff);
            st      <= S_IDLE;
          end
        S_DNV: begin
          volt_req <= volt_tab[dn_i];
          st       <= S_DNW;
        end
        default:
          if (vreg_ack) begin
            cur <= dn_i;
            irq <= (dn_i == eff);
            st  <= S_IDLE;
          end
      endcase
    end
  end

  assert_up_clk_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UP && !vreg_ack) |=> $stable(div_sel));
  assert_dn_volt_after_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DNW) |=> $stable(volt_req) && $stable(div_sel));
  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (current_idx != $past(current_idx)) |->
      ({1'b0, current_idx} == {1'b0, $past(current_idx)} + 1'b1 ||
       {1'b0, current_idx} + 1'b1 == {1'b0, $past(current_idx)}));
  assert_override_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (max_perf && st == S_IDLE) |=> st != S_DNV);
  assert_irq_at_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> current_idx == $past(target_idx));
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/dvfs_level_ctrl_tb.sv
`timescale 1ns/1ps
module dvfs_level_ctrl_tb;
  localparam int NLVL = 4;
  localparam int TOP  = NLVL - 1;

  logic       clk = 0, rst_n = 0;
  logic       req_we = 0, lut_we = 0, max_perf = 0, vreg_ack, extra_ack = 0;
  logic [6:0] req_pct = 0;
  logic [1:0] lut_idx = 0;
  logic [2:0] lut_div = 0;
  logic [3:0] lut_volt = 0;
  logic [2:0] div_sel;
  logic [3:0] volt_req;
  logic [1:0] target_idx, current_idx;
  logic       irq;
  logic       reg_ack = 0;

  int checks = 0, fails = 0, irq_cnt = 0, max_cur = 0;
  bit mon_on = 0;

  always #5 clk = ~clk;
  assign vreg_ack = reg_ack | extra_ack;

  dvfs_level_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_pct(req_pct),
    .lut_we(lut_we), .lut_idx(lut_idx), .lut_div(lut_div), .lut_volt(lut_volt),
    .max_perf(max_perf), .vreg_ack(vreg_ack), .div_sel(div_sel),
    .volt_req(volt_req), .target_idx(target_idx), .current_idx(current_idx),
    .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [3:0] lastv = 0;
  int cnt = 0;
  always @(negedge clk) begin
    reg_ack <= 1'b0;
    if (volt_req !== lastv) begin
      lastv = volt_req;
      cnt = 3;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) reg_ack <= 1'b1;
    end
  end

  logic [2:0] pdiv = 3'd3;
  logic [3:0] pvolt = 0;
  logic [1:0] pcur = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (int'(current_idx) > max_cur) max_cur = int'(current_idx);
      if (mon_on) begin
        if (div_sel < pdiv) begin
          chk(volt_req == 4'(TOP - int'(div_sel)), "R5 volt before faster clock", volt_req, TOP - int'(div_sel));
          chk(volt_req == pvolt, "R5 volt set in earlier cycle", volt_req, pvolt);
          chk(int'(current_idx) == TOP - int'(div_sel), "R5 index with divider", current_idx, TOP - int'(div_sel));
        end
        if (volt_req < pvolt) begin
          chk(int'(div_sel) == TOP - int'(volt_req), "R6 clock slowed before volt", div_sel, TOP - int'(volt_req));
          chk(div_sel == pdiv, "R6 divider changed earlier", div_sel, pdiv);
        end
        if (current_idx != pcur)
          chk(current_idx == pcur + 2'd1 || current_idx + 2'd1 == pcur, "R7 single step", current_idx, pcur);
      end
      pdiv = div_sel; pvolt = volt_req; pcur = current_idx;
    end
  end

  function automatic int exp_idx(input int r);
    int rr = (r > 100) ? 100 : r;
    int best = 0, bd = 1000;
    for (int i = 0; i < NLVL; i++) begin
      int lv = (i + 1) * 100 / NLVL;
      int d = (rr > lv) ? rr - lv : lv - rr;
      if (d <= bd) begin bd = d; best = i; end
    end
    return best;
  endfunction

  task automatic wr_req(input int v);
    req_pct = 7'(v); req_we = 1;
    @(negedge clk); req_we = 0;
  endtask

  task automatic settle();
    int st = 0;
    for (int i = 0; i < 300 && st < 10; i++) begin
      @(negedge clk);
      if (current_idx == target_idx) st++; else st = 0;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ic;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(current_idx == 0, "R1 reset current", current_idx, 0);
    chk(target_idx == 0, "R1 reset target", target_idx, 0);
    chk(div_sel == 3'd3, "R1 reset div", div_sel, 3);
    chk(volt_req == 0, "R1 reset volt", volt_req, 0);
    chk(irq == 0, "R1 reset irq", irq, 0);

    for (int v = 0; v < 128; v++) begin
      wr_req(v);
      chk(int'(target_idx) == exp_idx(v), "R2 rounding", target_idx, exp_idx(v));
    end
    wr_req(0);
    settle();
    mon_on = 1;

    ic = irq_cnt;
    wr_req(100);
    settle();
    chk(current_idx == 3, "R7 ramp up reached", current_idx, 3);
    chk(div_sel == 0 && volt_req == 3, "R5 top level settings", {div_sel, volt_req}, 3);
    chk(irq_cnt - ic == 1, "R9 one irq on arrival", irq_cnt - ic, 1);
    ic = irq_cnt;
    wr_req(30);
    settle();
    chk(current_idx == 0, "R7 ramp down reached", current_idx, 0);
    chk(div_sel == 3 && volt_req == 0, "R6 bottom level settings", {div_sel, volt_req}, 48);
    chk(irq_cnt - ic == 1, "R9 one irq on descent", irq_cnt - ic, 1);

    max_perf = 1;
    @(negedge clk);
    chk(target_idx == 3, "R3 override target", target_idx, 3);
    wr_req(50);
    chk(target_idx == 3, "R3 override beats write", target_idx, 3);
    settle();
    chk(current_idx == 3, "R3 override reached top", current_idx, 3);
    max_perf = 0;
    @(negedge clk);
    chk(target_idx == 1, "R4 return to latest write", target_idx, 1);
    settle();
    chk(current_idx == 1, "R4 settled at software level", current_idx, 1);

    ic = irq_cnt;
    extra_ack = 1; @(negedge clk); extra_ack = 0;
    repeat (5) @(negedge clk);
    chk(current_idx == 1, "R10 stray ack current", current_idx, 1);
    chk(div_sel == 2 && volt_req == 1, "R10 stray ack outputs", {div_sel, volt_req}, 33);
    chk(irq_cnt == ic, "R10 stray ack irq", irq_cnt - ic, 0);

    wr_req(0);
    settle();
    max_cur = 0;
    ic = irq_cnt;
    wr_req(100);
    for (int i = 0; i < 20 && volt_req == 0; i++) @(negedge clk);
    wr_req(0);
    settle();
    chk(max_cur == 1, "R8 step finished then turned", max_cur, 1);
    chk(current_idx == 0, "R8 new target reached", current_idx, 0);
    chk(irq_cnt - ic == 1, "R9 irq only at final target", irq_cnt - ic, 1);

    mon_on = 0;
    lut_idx = 2; lut_div = 3'd5; lut_volt = 4'd9; lut_we = 1;
    @(negedge clk); lut_we = 0;
    wr_req(75);
    settle();
    chk(current_idx == 2, "R11 reached level 2", current_idx, 2);
    chk(div_sel == 5, "R11 new divider", div_sel, 5);
    chk(volt_req == 9, "R11 new voltage", volt_req, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule